// File: doc/BRIEF.md
# Three-Phase Register-ALU Processor Core

This block is a small 16-bit processor that runs only register-to-register arithmetic and logic instructions. It contains a 128-word read-only instruction store filled with a boot program when the device is configured. It also holds a program counter, an instruction register, an eight-entry register file, a four-function ALU and a controller that spends exactly three clock cycles on every instruction. Register addresses and the ALU function are decoded straight from fields of the instruction register. The controller drives only three strobes: instruction load, register write and counter advance.

Apart from clock and reset, the block has no functional inputs. Its outputs are observation ports. They show the program counter, the instruction register and a registered copy of the last register-file write, so a testbench can follow execution. The register file is seeded with all ones in entry 0. A program made only of ALU instructions can therefore produce nonzero values.

Top module: `rac_core_top`

## Requirements
- R1: An instruction word is legal when bits 15..11 are all zero. Bits 10..9 hold the function code, bits 8..6 the destination register, bits 5..3 source B and bits 2..0 source A. For a legal word, `dbg_wr_sel` reports the destination field.
- R2: The function codes are 00 = A+B, 01 = A-B, 10 = A AND B and 11 = A OR B, all modulo 2^16. The written value appears on `dbg_wr_data`.
- R3: Every instruction takes three cycles. The first is a fetch cycle, whose closing edge loads `mem[pc]` into the instruction register shown on `dbg_ir`. The second is an execute cycle, whose closing edge writes the register file. The third is an advance cycle, whose closing edge increments the PC. After that the core returns to fetch.
- R4: After the execute edge of a legal instruction, `dbg_wr_en` is 1 for exactly the advance cycle. At the same edge `dbg_wr_sel` and `dbg_wr_data` take the destination and result. Otherwise they keep their last values, and `dbg_wr_en` is 0 in all other cycles.
- R5: The 7-bit PC changes only at the end of an advance cycle. It changes by +1 and wraps from 127 to 0.
- R6: Synchronous active-high reset sets the PC to 0, the instruction register to 0, the write-report outputs to 0 and the controller to fetch. It clears registers 1..7 and sets register 0 to 16'hFFFF.
- R7: A word with any of bits 15..11 set writes no register and leaves `dbg_wr_en` at 0. It still takes three cycles and advances the PC.
- R8: The boot program at address a (0..127) is 16'h8800 + a when a mod 16 = 15. Otherwise it is a legal word with function (a/8) mod 4, destination (a+1) mod 8, source B (a/16) mod 8 and source A a mod 8.
- R9: When the destination register is also a source, the operands are the values held before that instruction's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 7 | Current program counter |
| dbg_ir | output | 16 | Current instruction register |
| dbg_wr_en | output | 1 | Register write performed at the previous edge |
| dbg_wr_sel | output | 3 | Destination of the last register write |
| dbg_wr_data | output | 16 | Value of the last register write |

## Verification
The boot program sweeps every source pair and all four function codes. Register 0 starts at all ones and every other register at zero, so the early additions and subtractions give carry and borrow patterns that separate add from subtract and AND from OR. A reference model steps alongside the core for three passes over the whole program. This tells apart wrap of the PC, the periodic no-operation words, and results that feed back into their own sources. A reset asserted in the middle of an execute phase shows that the seed value of register 0 and the phase counter are restored, not carried over.

// File: rtl/rac_pkg.sv
package rac_pkg;

  localparam int WORD_W     = 16;
  localparam int RSEL_W     = 3;
  localparam int NUM_REGS   = 1 << RSEL_W;
  localparam int FN_W       = 2;
  localparam int RSVD_W     = WORD_W - FN_W - 3 * RSEL_W;
  localparam int IMEM_DEPTH = 128;
  localparam int PC_W       = $clog2(IMEM_DEPTH);

  typedef enum logic [1:0] {
    PH_FETCH   = 2'd0,
    PH_EXECUTE = 2'd1,
    PH_ADVANCE = 2'd2
  } phase_t;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu_fn_t;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    alu_fn_t           fn;
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] src_b;
    logic [RSEL_W-1:0] src_a;
  } insn_t;

  // Boot image generator: one word per address.
  function automatic logic [WORD_W-1:0] boot_word(input int unsigned addr);
    logic [6:0] a7;
    insn_t      w;
    a7 = 7'(addr);
    if (a7[3:0] == 4'hF) begin
      return 16'h8800 + {9'd0, a7};
    end
    w.rsvd  = '0;
    w.fn    = alu_fn_t'(a7[4:3]);
    w.dst   = 3'(a7[2:0] + 3'd1);
    w.src_b = a7[6:4];
    w.src_a = a7[2:0];
    return w;
  endfunction

endpackage

// File: rtl/rac_imem.sv
module rac_imem
  import rac_pkg::*;
#(
  parameter int DEPTH = IMEM_DEPTH,
  parameter int DW    = WORD_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = DW'(boot_word(i));
    end
  end

  // Registered read port; the output register doubles as the IR.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rom[rd_addr];
    end
  end

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q)); // R3

endmodule

// File: rtl/rac_regfile.sv
module rac_regfile
  import rac_pkg::*;
#(
  parameter int N        = NUM_REGS,
  parameter int DW       = WORD_W,
  parameter logic [DW-1:0] SEED0 = '1,
  localparam int SW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rsel_a,
  input  logic [SW-1:0] rsel_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [N-1:0][DW-1:0] rf_q;

  for (genvar g = 0; g < N; g++) begin : g_entry
    localparam logic [DW-1:0] RST_VAL = (g == 0) ? SEED0 : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        rf_q[g] <= RST_VAL;
      end else if (we && (wsel == SW'(g))) begin
        rf_q[g] <= wdata;
      end
    end
  end

  assign rdata_a = rf_q[rsel_a];
  assign rdata_b = rf_q[rsel_b];

  AST_RF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rf_q)); // R7

  AST_RF_SEED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rf_q[0] == SEED0)); // R6

endmodule

// File: rtl/rac_alu.sv
module rac_alu
  import rac_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  alu_fn_t       fn,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] res
);

  always_comb begin
    unique case (fn)
      FN_ADD:  res = opa + opb;
      FN_SUB:  res = opa - opb;
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (fn == FN_SUB) begin
      AST_SUB_INVERSE: assert (DW'(res + opb) == opa); // R2
    end
  end

endmodule

// File: rtl/rac_ctrl.sv
module rac_ctrl
  import rac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic insn_legal,
  output logic load_ir,
  output logic wr_reg,
  output logic pc_inc
);

  phase_t ph_q, ph_d;

  always_comb begin
    unique case (ph_q)
      PH_FETCH:   ph_d = PH_EXECUTE;
      PH_EXECUTE: ph_d = PH_ADVANCE;
      default:    ph_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_FETCH;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign load_ir = (ph_q == PH_FETCH);
  assign wr_reg  = (ph_q == PH_EXECUTE) && insn_legal;
  assign pc_inc  = (ph_q == PH_ADVANCE);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_ir, wr_reg, pc_inc})); // R3

  AST_FETCH_AFTER_ADV: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> load_ir); // R3

  AST_NO_BACK2BACK_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_ir |=> !load_ir && !pc_inc); // R3

endmodule

// File: rtl/rac_core_top.sv
module rac_core_top
  import rac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   dbg_pc,
  output logic [WORD_W-1:0] dbg_ir,
  output logic              dbg_wr_en,
  output logic [RSEL_W-1:0] dbg_wr_sel,
  output logic [WORD_W-1:0] dbg_wr_data
);

  logic [PC_W-1:0]   pc_q;
  logic [WORD_W-1:0] ir_q;
  insn_t             ir_f;
  logic              legal;
  logic              load_ir, wr_reg, pc_inc;
  logic [WORD_W-1:0] opa, opb, alu_y;
  logic              wr_en_q;
  logic [RSEL_W-1:0] wr_sel_q;
  logic [WORD_W-1:0] wr_data_q;

  assign ir_f  = insn_t'(ir_q);
  assign legal = (ir_f.rsvd == '0);

  rac_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .insn_legal (legal),
    .load_ir    (load_ir),
    .wr_reg     (wr_reg),
    .pc_inc     (pc_inc)
  );

  rac_imem #(.DEPTH(IMEM_DEPTH), .DW(WORD_W)) u_imem (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (load_ir),
    .rd_addr (pc_q),
    .rd_q    (ir_q)
  );

  rac_regfile #(.N(NUM_REGS), .DW(WORD_W), .SEED0('1)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_reg),
    .wsel    (ir_f.dst),
    .wdata   (alu_y),
    .rsel_a  (ir_f.src_a),
    .rsel_b  (ir_f.src_b),
    .rdata_a (opa),
    .rdata_b (opb)
  );

  rac_alu #(.DW(WORD_W)) u_alu (
    .fn  (ir_f.fn),
    .opa (opa),
    .opb (opb),
    .res (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (pc_inc) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_q   <= 1'b0;
      wr_sel_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= wr_reg;
      if (wr_reg) begin
        wr_sel_q  <= ir_f.dst;
        wr_data_q <= alu_y;
      end
    end
  end

  assign dbg_pc      = pc_q;
  assign dbg_ir      = ir_q;
  assign dbg_wr_en   = wr_en_q;
  assign dbg_wr_sel  = wr_sel_q;
  assign dbg_wr_data = wr_data_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_q) |-> (pc_q == PC_W'($past(pc_q) + 1))); // R5

  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!legal && !load_ir && !pc_inc) |=> !dbg_wr_en); // R7

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_en |=> !dbg_wr_en); // R4

endmodule

// File: tb/rac_core_top_tb_top.sv
module rac_core_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  dbg_pc;
  logic [15:0] dbg_ir;
  logic        dbg_wr_en;
  logic [2:0]  dbg_wr_sel;
  logic [15:0] dbg_wr_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rac_core_top dut_i (
    .clk         (clk),
    .rst         (rst),
    .dbg_pc      (dbg_pc),
    .dbg_ir      (dbg_ir),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_sel  (dbg_wr_sel),
    .dbg_wr_data (dbg_wr_data)
  );

  // Reference model state
  logic [15:0] m_reg [8];
  int          m_pc, m_phase;
  logic [15:0] m_ir;
  logic        m_wen;
  logic [2:0]  m_sel;
  logic [15:0] m_data;
  bit          m_fresh;

  function automatic logic [15:0] prog(int a);   // R8
    int w;
    if (a % 16 == 15) w = 'h8800 + a;
    else w = (((a / 8) % 4) << 9) + (((a + 1) % 8) << 6) + (((a / 16) % 8) << 3) + (a % 8);
    return w[15:0];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0000;
    m_reg[0] = 16'hFFFF;
    m_pc = 0; m_phase = 0; m_ir = 0; m_wen = 0; m_sel = 0; m_data = 0;
    m_fresh = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      model_reset();
    end else begin
      m_fresh = 0;
      case (m_phase)
        0: begin m_ir = prog(m_pc); m_wen = 0; m_phase = 1; end
        1: begin
          if (m_ir[15:11] == 0) begin
            logic [15:0] a, b, r;
            a = m_reg[m_ir[2:0]];
            b = m_reg[m_ir[5:3]];
            case (m_ir[10:9])
              2'd0: r = a + b;
              2'd1: r = a - b;
              2'd2: r = a & b;
              default: r = a | b;
            endcase
            m_reg[m_ir[8:6]] = r;
            m_wen = 1; m_sel = m_ir[8:6]; m_data = r;
          end else begin
            m_wen = 0;
          end
          m_phase = 2;
        end
        default: begin m_pc = (m_pc + 1) % 128; m_wen = 0; m_phase = 0; end
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      string rr;
      bit    self_ref;
      rr = m_fresh ? "R6" : "";
      self_ref = (m_ir[8:6] == m_ir[2:0]) || (m_ir[8:6] == m_ir[5:3]);
      chk(m_fresh ? rr : "R5", "pc", int'(dbg_pc), m_pc);
      chk(m_fresh ? rr : "R3", "ir", int'(dbg_ir), int'(m_ir));
      chk(m_fresh ? rr : (m_ir[15:11] != 0 ? "R7" : "R4"), "wr_en", int'(dbg_wr_en), int'(m_wen));
      chk(m_fresh ? rr : "R1", "wr_sel", int'(dbg_wr_sel), int'(m_sel));
      chk(m_fresh ? rr : (self_ref ? "R9" : "R2"), "wr_data", int'(dbg_wr_data), int'(m_data));
    end
  end

  // Explicit spot checks on the seed and first result (R6, R2, R8).
  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // Address 0: add r1 = r0 + r0 = FFFF + FFFF
    chk("R8", "first word", int'(dbg_ir), 16'h0040);
    chk("R6", "seeded sum", int'(dbg_wr_data), 16'hFFFE);
    repeat (700) @(negedge clk);
    // Land on an execute phase, then reset there.
    while (m_phase != 1) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (1000) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule